// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional data buses, called A and B, and carries data between them in either direction. Each direction has its own capture register with its own clock. Each direction also has a select that chooses between the live value on the far bus and the value held in that direction's register. A separate output enable controls each port. The enables have opposite polarity: the B-side enable is active high and the A-side enable is active low. With these controls the block can isolate the buses, pass data straight through, store data, replay stored data, or hold both buses at their last value by feeding each port back onto itself.

Each bus pin is split into an input, an output and an output-enable, so the block stays synthesizable. Tri-state resolution and any other drivers on the buses are outside the block. Capture can never be suppressed: a rising clock edge always loads its register. The block moves plain data with no handshake, so there is no back-pressure, and every control pin is a static level.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On every rising edge of `clk_ab`, the A-to-B register loads `a_in`, whatever the selects and enables are set to.
- R2: On every rising edge of `clk_ba`, the B-to-A register loads `b_in`, whatever the selects and enables are set to.
- R3: `b_out` equals `a_in` when `sel_ab` is 0 and equals the A-to-B register when `sel_ab` is 1. This holds whether or not `b_oe` is on.
- R4: `a_out` equals `b_in` when `sel_ba` is 0 and equals the B-to-A register when `sel_ba` is 1. This holds whether or not `a_oe` is on.
- R5: `b_oe` follows `oe_ab`, which is active high. `a_oe` is the inverse of `oe_ba_n`, which is active low.
- R6: With `oe_ab`=0 and `oe_ba_n`=1, both `a_oe` and `b_oe` are 0, so both buses are isolated. Clock edges still capture into either register in this mode.
- R7: With both enables active and both selects 0, each bus drives its own value back onto itself. After the external drivers release, both buses keep their last value.
- R8: With both enables active and both selects 1, the stored A data drives B and the stored B data drives A at the same time.
- R9: While `rst_n` is low, both registers are cleared to zero, asynchronously.
- R10: A clock edge in one direction leaves the other direction's register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| sel_ab | input | 1 | B-port source: 0 selects live A, 1 selects stored A |
| sel_ba | input | 1 | A-port source: 0 selects live B, 1 selects stored B |
| oe_ab | input | 1 | Enable for the B-port drivers, active high |
| oe_ba_n | input | 1 | Enable for the A-port drivers, active low |
| a_in | input | W | Resolved value of bus A |
| a_out | output | W | Value the block offers to bus A |
| a_oe | output | 1 | Block drives bus A when 1 |
| b_in | input | W | Resolved value of bus B |
| b_out | output | W | Value the block offers to bus B |
| b_oe | output | 1 | Block drives bus B when 1 |

## Verification
The assertions check three things at every capture edge. Each register's content reappears on its port once the stored source is selected. The live path follows the opposite bus. The two enables keep their opposite polarities. The bench scenarios cover behaviour that depends on how the external bus is resolved: the held value after the drivers release in the feedback configuration, the isolation mode still capturing, and one direction's clock leaving the other register unchanged.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // loads on every rising edge; no enable by design
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/dir_path.sv
module dir_path
  import xcvr_pkg::*;
#(
  parameter int W             = 8,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         sel,
  input  logic         oe_pin,
  output logic [W-1:0] dout,
  output logic         doe
);
  src_e src;
  assign src = src_e'(sel);

  always_comb begin
    unique case (src)
      SRC_STORED: dout = stored;
      default:    dout = live;
    endcase
  end

  generate
    if (OE_ACTIVE_LOW) begin : g_oe_low
      assign doe = ~oe_pin;
    end else begin : g_oe_high
      assign doe = oe_pin;
    end
  endgenerate
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [W-1:0] held_ab;
  logic [W-1:0] held_ba;

  capture_reg #(.W(W)) u_reg_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(held_ab)
  );

  capture_reg #(.W(W)) u_reg_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(held_ba)
  );

  dir_path #(.W(W), .OE_ACTIVE_LOW(1'b0)) u_to_b (
    .live(a_in), .stored(held_ab), .sel(sel_ab), .oe_pin(oe_ab),
    .dout(b_out), .doe(b_oe)
  );

  dir_path #(.W(W), .OE_ACTIVE_LOW(1'b1)) u_to_a (
    .live(b_in), .stored(held_ba), .sel(sel_ba), .oe_pin(oe_ba_n),
    .dout(a_out), .doe(a_oe)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         oe_ab,
  input logic         oe_ba_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  // R1: value taken at one clk_ab edge is what the stored path shows at the next
  p_store_ab_r1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    1'b1 |=> (!sel_ab || b_out == $past(a_in)));

  // R2: same for the B-to-A direction
  p_store_ba_r2: assert property (@(posedge clk_ba) disable iff (!rst_n)
    1'b1 |=> (!sel_ba || a_out == $past(b_in)));

  // R3: live path to B
  p_live_ab_r3: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !sel_ab |-> b_out == a_in);

  // R4: live path to A
  p_live_ba_r4: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !sel_ba |-> a_out == b_in);

  // R5: enable polarities
  p_oe_pol_r5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe == oe_ab) && (a_oe == !oe_ba_n));
endmodule

bind bus_xcvr_reg xcvr_checker #(.W(W)) u_chk (
  .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
  .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, clk_ab = 1'b0, clk_ba = 1'b0;
  logic sel_ab = 1'b0, sel_ba = 1'b0, oe_ab = 1'b0, oe_ba_n = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // external bus model
  logic [W-1:0] ext_a = '0, ext_b = '0, bus_a = '0, bus_b = '0;
  logic ext_a_en = 1'b1, ext_b_en = 1'b1;

  bus_xcvr_reg #(.W(W)) u0 (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // {oe_ab, oe_ba_n, sel_ab, sel_ba, exp_a_out, exp_b_out, exp_a_oe, exp_b_oe}
  // stored A = 3C, stored B = C3, live A = 5A, live B = A5
  localparam logic [21:0] VEC [16] = '{
    {4'h0, 8'hA5, 8'h5A, 2'b10}, {4'h1, 8'hC3, 8'h5A, 2'b10},
    {4'h2, 8'hA5, 8'h3C, 2'b10}, {4'h3, 8'hC3, 8'h3C, 2'b10},
    {4'h4, 8'hA5, 8'h5A, 2'b00}, {4'h5, 8'hC3, 8'h5A, 2'b00},
    {4'h6, 8'hA5, 8'h3C, 2'b00}, {4'h7, 8'hC3, 8'h3C, 2'b00},
    {4'h8, 8'hA5, 8'h5A, 2'b11}, {4'h9, 8'hC3, 8'h5A, 2'b11},
    {4'hA, 8'hA5, 8'h3C, 2'b11}, {4'hB, 8'hC3, 8'h3C, 2'b11},
    {4'hC, 8'hA5, 8'h5A, 2'b01}, {4'hD, 8'hC3, 8'h5A, 2'b01},
    {4'hE, 8'hA5, 8'h3C, 2'b01}, {4'hF, 8'hC3, 8'h3C, 2'b01}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // resolve both buses: external driver wins, else block driver, else keep
  task automatic settle();
    for (int k = 0; k < 3; k++) begin
      #1;
      bus_a = ext_a_en ? ext_a : (a_oe ? a_out : bus_a);
      bus_b = ext_b_en ? ext_b : (b_oe ? b_out : bus_b);
      a_in = bus_a;
      b_in = bus_b;
    end
    #1;
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    ext_a = a; ext_b = b; ext_a_en = 1'b1; ext_b_en = 1'b1;
    settle();
  endtask

  task automatic pulse_ab();
    @(negedge clk); clk_ab = 1'b1;
    @(negedge clk); clk_ab = 1'b0;
  endtask

  task automatic pulse_ba();
    @(negedge clk); clk_ba = 1'b1;
    @(negedge clk); clk_ba = 1'b0;
  endtask

  task automatic ctrl(input logic oab, input logic oban, input logic sab, input logic sba);
    oe_ab = oab; oe_ba_n = oban; sel_ab = sab; sel_ba = sba;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state
    drive(8'h77, 8'h88);
    ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    check("R9 reset clears A-to-B", b_out, 8'h00);
    check("R9 reset clears B-to-A", a_out, 8'h00);
    check("R6 isolation a_oe", {7'd0, a_oe}, 8'h00);
    check("R6 isolation b_oe", {7'd0, b_oe}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // preload registers and walk every enable/select combination
    drive(8'h3C, 8'hC3);
    pulse_ab(); pulse_ba();
    drive(8'h5A, 8'hA5);
    foreach (VEC[i]) begin
      @(negedge clk);
      ctrl(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18]);
      check("R3 b_out in vector", b_out, VEC[i][9:2]);
      check("R4 a_out in vector", a_out, VEC[i][17:10]);
      check("R5 a_oe in vector", {7'd0, a_oe}, {7'd0, VEC[i][1]});
      check("R5 b_oe in vector", {7'd0, b_oe}, {7'd0, VEC[i][0]});
    end

    // R1 R6 R10: capture while isolated, other register untouched
    ctrl(1'b0, 1'b1, 1'b1, 1'b1);
    drive(8'h11, 8'h22);
    pulse_ab();
    settle();
    check("R1 capture while isolated", b_out, 8'h11);
    check("R10 B-to-A kept on clk_ab", a_out, 8'hC3);
    // R2: capture with selects live and enables active
    ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    drive(8'h33, 8'h44);
    pulse_ba();
    ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    check("R2 capture regardless of controls", a_out, 8'h44);
    check("R10 A-to-B kept on clk_ba", b_out, 8'h11);
    // R8: both stored values replayed together
    check("R8 stored A on B", b_oe ? b_out : 8'hXX, 8'h11);
    check("R8 stored B on A", a_oe ? a_out : 8'hXX, 8'h44);

    // R7: feedback hold after external drivers release
    ctrl(1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    ext_a = 8'h96; ext_a_en = 1'b1; ext_b_en = 1'b0;
    settle();
    check("R7 A drives B through loop", bus_b, 8'h96);
    @(negedge clk);
    ext_a_en = 1'b0;
    settle();
    repeat (3) settle();
    check("R7 bus A held", bus_a, 8'h96);
    check("R7 bus B held", bus_b, 8'h96);

    // R9: asynchronous clear in mid-run
    drive(8'h5A, 8'hA5);
    ctrl(1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk); #2 rst_n = 1'b0;
    settle();
    check("R9 async clear A-to-B", b_out, 8'h00);
    check("R9 async clear B-to-A", a_out, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule